// File: doc/BRIEF.md
# Keyed One-Shot-Enable Watchdog

This block is a hardware watchdog for a small controller core. It comes out of reset switched off. Software switches it on by writing a two-byte key, 1Eh followed by E1h, to a write-only service register. After that nothing except a reset can switch it off. Once it runs, a 13-bit counter advances on each machine-cycle strobe. Software must write the same key again to clear the counter before the counter reaches its limit. If the counter does reach the limit, the block switches itself off, clears its count and raises a reset request that lasts a fixed number of oscillator clocks. A separate drive-enable tells the pad logic whether to drive the reset pin during that request.

Two low-power states change how the counter behaves. Idle pauses it only when the halt-in-idle bit is set. Power-down always freezes it. After a wake-up from power-down by interrupt, the counter stays frozen until the wake-interrupt line has returned high. This keeps the watchdog from firing while the interrupt is held low to let the oscillator settle.

Top module: `keyed_wdt`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the watchdog is disabled, `rst_pulse` and `rst_drive_en` are 0, and any count held before the reset is discarded.
- R2: A write of E1h to the service register that directly follows a write of 1Eh enables the watchdog with its count at zero. A lone E1h, or no key at all, leaves it disabled, so no number of strobes produces a reset request.
- R3: Once enabled, service-register writes that do not complete the key, such as 00h, never disable the watchdog. Only a reset or its own overflow can disable it.
- R4: While enabled and running, the count advances by one for each clock in which `mc_tick` is 1. The 8191st advance after the watchdog is enabled or serviced raises `rst_pulse` one clock edge later, and the 8190th advance does not.
- R5: A completed key written while the watchdog is enabled clears the count, so that another 8191 advances are needed before overflow. A key that completes in the same cycle as the overflow advance takes priority.
- R6: On overflow, `rst_pulse` stays high for exactly 98 clock cycles.
- R7: `rst_drive_en` equals `rst_pulse` while `rst_out_dis` is 0, and stays 0 while `rst_out_dis` is 1.
- R8: With `idle` at 1, strobes still advance the count when `idle_halt` is 0. When `idle_halt` is 1 they do not, and counting resumes from the held value once `idle` returns to 0.
- R9: While `pdown` is 1 the count is frozen, whatever `mc_tick` does.
- R10: If `wake_n` is 0 while `pdown` is 1, the count stays frozen after `pdown` drops and remains frozen until the first clock edge at which `wake_n` is 1.
- R11: A service write of any value other than E1h directly after 1Eh cancels the pending key. A repeated 1Eh keeps the key pending, so 1Eh, 1Eh, E1h is a valid key.
- R12: An overflow also disables the watchdog and clears its count. Without a new key, no further reset request follows, however many strobes arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| svc_wr | input | 1 | Write strobe for the service register |
| svc_data | input | 8 | Data byte written to the service register |
| idle | input | 1 | Core is in idle |
| pdown | input | 1 | Core is in power-down |
| wake_n | input | 1 | Power-down wake-interrupt level, active low |
| rst_out_dis | input | 1 | 1 keeps the reset pin input-only on timeout |
| idle_halt | input | 1 | 1 pauses counting during idle |
| rst_pulse | output | 1 | Reset request, 98 clocks long, on overflow |
| rst_drive_en | output | 1 | Drive enable for the reset pin |

## Verification
The hardest situation to reach is the wake hold. It needs a power-down that sees `wake_n` low, then a stretch in which `pdown` is already 0 but `wake_n` is still low, with strobes running throughout. The stimulus builds this up in stages: it runs part of a count, enters power-down with `wake_n` low, leaves power-down while keeping `wake_n` low for thousands of strobes, then releases `wake_n`. The test then checks that the reset request arrives exactly on the advance that completes 8191 counted strobes. Because the count cannot be read, every hold and pause is measured by the cycle in which `rst_pulse` rises.

// File: rtl/keyed_wdt_pkg.sv
// Shared constants and types for the keyed watchdog.
package keyed_wdt_pkg;
    localparam logic [7:0] KEY_FIRST  = 8'h1E;
    localparam logic [7:0] KEY_SECOND = 8'hE1;

    typedef enum logic {
        KEY_WAIT  = 1'b0,
        KEY_HALF  = 1'b1
    } key_state_e;
endpackage

// File: rtl/keyed_wdt_keyseq.sv
// Key recogniser for the service register.
// Tracks whether the first key byte has just been written. It signals
// key_ok in the cycle in which the second byte completes the key.
// Assumes the writes come as single-cycle strobes. abort drops a pending half key.
module keyed_wdt_keyseq
    import keyed_wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       wr,
    input  logic [7:0] data,
    output logic       key_ok
);
    key_state_e state_q;

    // Key completes when the second byte follows a pending first byte.
    always_comb begin
        key_ok = wr && (state_q == KEY_HALF) && (data == KEY_SECOND);
    end

    // Advance the key state on every write; any other byte cancels it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KEY_WAIT;
        end else if (abort) begin
            state_q <= KEY_WAIT;
        end else if (wr) begin
            state_q <= (data == KEY_FIRST) ? KEY_HALF : KEY_WAIT;
        end
    end
endmodule

// File: rtl/keyed_wdt_gate.sv
// Run qualifier for the watchdog counter.
// Combines power-down, idle with the halt bit, and the wake hold that
// follows an interrupt wake from power-down. Assumes that wake_n is
// already synchronised to clk.
module keyed_wdt_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic idle_halt,
    input  logic pdown,
    input  logic wake_n,
    output logic run_ok
);
    logic wake_hold_q;

    // Hold set by a low wake line in power-down, released when it goes high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_hold_q <= 1'b0;
        end else if (pdown && !wake_n) begin
            wake_hold_q <= 1'b1;
        end else if (wake_n) begin
            wake_hold_q <= 1'b0;
        end
    end

    // Counting is allowed only outside power-down, wake hold and halted idle.
    always_comb begin
        run_ok = !pdown && !wake_hold_q && !(idle && idle_halt);
    end
endmodule

// File: rtl/keyed_wdt_count.sv
// Enable latch and timeout counter.
// The enable sets on a completed key and clears only on reset or overflow.
// The counter clears on every key and flags overflow on the advance that
// would take it to its all-ones value. A key in the same cycle wins.
module keyed_wdt_count #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run_ok,
    input  logic             key_ok,
    output logic             enabled,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_LAST = {{(CNT_W-1){1'b1}}, 1'b0};

    logic advance;

    // Decide whether this cycle advances or overflows.
    always_comb begin
        advance = enabled && tick && run_ok;
        ovf     = advance && !key_ok && (count == CNT_LAST);
    end

    // Enable and count update with key taking priority over overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled <= 1'b0;
            count   <= '0;
        end else if (key_ok) begin
            enabled <= 1'b1;
            count   <= '0;
        end else if (ovf) begin
            enabled <= 1'b0;
            count   <= '0;
        end else if (advance) begin
            count   <= count + 1'b1;
        end
    end
endmodule

// File: rtl/keyed_wdt_pulse.sv
// Reset-out stretcher: turns an overflow strobe into a request of
// PULSE_LEN clocks and gates the pin drive with the disable bit.
module keyed_wdt_pulse #(
    parameter int PULSE_LEN = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic out_dis,
    output logic pulse,
    output logic drive_en
);
    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] LOAD = PW'(PULSE_LEN);

    logic [PW-1:0] left_q;

    // Load the length on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Request is high while cycles remain; the pin drives unless disabled.
    always_comb begin
        pulse    = (left_q != '0);
        drive_en = pulse && !out_dis;
    end
endmodule

// File: rtl/keyed_wdt.sv
// Keyed one-shot-enable watchdog, top level.
// Wires the key recogniser, run qualifier, counter and pulse stretcher.
// Assumes one oscillator clock domain, with every input synchronous to clk.
module keyed_wdt #(
    parameter int CNT_W     = 13,
    parameter int PULSE_LEN = 98
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mc_tick,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    input  logic       idle,
    input  logic       pdown,
    input  logic       wake_n,
    input  logic       rst_out_dis,
    input  logic       idle_halt,
    output logic       rst_pulse,
    output logic       rst_drive_en
);
    logic             key_ok;
    logic             run_ok;
    logic             wdt_en;
    logic [CNT_W-1:0] wdt_cnt;
    logic             wdt_ovf;

    keyed_wdt_keyseq u_keyseq (
        .clk    (clk),
        .rst_n  (rst_n),
        .abort  (wdt_ovf),
        .wr     (svc_wr),
        .data   (svc_data),
        .key_ok (key_ok)
    );

    keyed_wdt_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (idle),
        .idle_halt (idle_halt),
        .pdown     (pdown),
        .wake_n    (wake_n),
        .run_ok    (run_ok)
    );

    keyed_wdt_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (mc_tick),
        .run_ok  (run_ok),
        .key_ok  (key_ok),
        .enabled (wdt_en),
        .count   (wdt_cnt),
        .ovf     (wdt_ovf)
    );

    keyed_wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (wdt_ovf),
        .out_dis  (rst_out_dis),
        .pulse    (rst_pulse),
        .drive_en (rst_drive_en)
    );
endmodule

// File: rtl/keyed_wdt_chk.sv
// Property checker for the keyed watchdog, bound to every keyed_wdt instance.
module keyed_wdt_chk #(
    parameter int CNT_W     = 13,
    parameter int PULSE_LEN = 98
) (
    input logic             clk,
    input logic             rst_n,
    input logic             svc_wr,
    input logic [7:0]       svc_data,
    input logic             idle,
    input logic             idle_halt,
    input logic             pdown,
    input logic             rst_out_dis,
    input logic             rst_pulse,
    input logic             rst_drive_en,
    input logic             key_ok,
    input logic             wdt_en,
    input logic [CNT_W-1:0] wdt_cnt
);
    int unsigned hi_len;

    // Length of the current high run of rst_pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len <= 0;
        end else if (rst_pulse) begin
            hi_len <= hi_len + 1;
        end else begin
            hi_len <= 0;
        end
    end

    // R2
    enable_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_en) |-> $past(svc_wr && svc_data == 8'hE1));

    // R3
    disable_only_by_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wdt_en) && $past(rst_n)) |-> $rose(rst_pulse));

    // R6
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rst_pulse) && $past(rst_n)) |-> (hi_len == PULSE_LEN));

    // R7
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_drive_en |-> (rst_pulse && !rst_out_dis));

    // R8
    idle_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && idle_halt && !key_ok) |=> $stable(wdt_cnt));

    // R9
    pdown_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pdown && !key_ok) |=> $stable(wdt_cnt));

    // R12
    ovf_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pulse) |-> (!wdt_en && wdt_cnt == '0));
endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .svc_wr       (svc_wr),
    .svc_data     (svc_data),
    .idle         (idle),
    .idle_halt    (idle_halt),
    .pdown        (pdown),
    .rst_out_dis  (rst_out_dis),
    .rst_pulse    (rst_pulse),
    .rst_drive_en (rst_drive_en),
    .key_ok       (key_ok),
    .wdt_en       (wdt_en),
    .wdt_cnt      (wdt_cnt)
);

// File: tb/keyed_wdt_tb.sv
// Self-checking bench for keyed_wdt: a vector table of count phases,
// then directed tests for keys, wake hold, pulse shape and reset.
module keyed_wdt_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       idle = 1'b0;
    logic       pdown = 1'b0;
    logic       wake_n = 1'b1;
    logic       rst_out_dis = 1'b0;
    logic       idle_halt = 1'b0;
    logic       rst_pulse;
    logic       rst_drive_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    keyed_wdt u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mc_tick      (mc_tick),
        .svc_wr       (svc_wr),
        .svc_data     (svc_data),
        .idle         (idle),
        .pdown        (pdown),
        .wake_n       (wake_n),
        .rst_out_dis  (rst_out_dis),
        .idle_halt    (idle_halt),
        .rst_pulse    (rst_pulse),
        .rst_drive_en (rst_drive_en)
    );

    typedef struct packed {
        logic [15:0] pre;
        logic [15:0] mid;
        logic        mid_idle;
        logic        mid_halt;
        logic        mid_pd;
        logic [15:0] post;
        logic        exp_pulse;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'd8190, 16'd0,    1'b0, 1'b0, 1'b0, 16'd0,    1'b0, 8'd4},  // R4 one short
        '{16'd8191, 16'd0,    1'b0, 1'b0, 1'b0, 16'd0,    1'b1, 8'd4},  // R4 exact
        '{16'd3000, 16'd1000, 1'b1, 1'b1, 1'b0, 16'd5190, 1'b0, 8'd8},  // R8 halted idle
        '{16'd3000, 16'd1000, 1'b1, 1'b1, 1'b0, 16'd5191, 1'b1, 8'd8},  // R8 resume
        '{16'd3000, 16'd5190, 1'b1, 1'b0, 1'b0, 16'd0,    1'b0, 8'd8},  // R8 idle counts
        '{16'd3000, 16'd5191, 1'b1, 1'b0, 1'b0, 16'd0,    1'b1, 8'd8},  // R8 idle counts
        '{16'd3000, 16'd1000, 1'b0, 1'b0, 1'b1, 16'd5190, 1'b0, 8'd9},  // R9 frozen
        '{16'd3000, 16'd1000, 1'b0, 1'b0, 1'b1, 16'd5191, 1'b1, 8'd9}   // R9 frozen
    };

    task automatic check(input logic got, input logic exp, input string tag, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, got, exp);
        end
    endtask

    task automatic check_int(input int got, input int exp, input string tag, input string what);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        svc_wr = 1'b1;
        svc_data = d;
        @(negedge clk);
        svc_wr = 1'b0;
    endtask

    task automatic run(input int n);
        if (n > 0) begin
            mc_tick = 1'b1;
            repeat (n) @(negedge clk);
            mc_tick = 1'b0;
        end
    endtask

    task automatic arm();
        wr(8'h1E);
        wr(8'hE1);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int len;
        @(negedge clk);
        do_reset();
        // R1 reset state
        check(rst_pulse, 1'b0, "R1", "pulse after reset");
        check(rst_drive_en, 1'b0, "R1", "drive after reset");

        // Vector table: R4 R8 R9
        for (int i = 0; i < NV; i++) begin
            do_reset();
            arm();
            run(int'(VECS[i].pre));
            idle = VECS[i].mid_idle;
            idle_halt = VECS[i].mid_halt;
            pdown = VECS[i].mid_pd;
            run(int'(VECS[i].mid));
            idle = 1'b0;
            idle_halt = 1'b0;
            pdown = 1'b0;
            run(int'(VECS[i].post));
            check(rst_pulse, VECS[i].exp_pulse, $sformatf("R%0d", VECS[i].req),
                  $sformatf("vector %0d", i));
        end

        // R6 R7 pulse shape, then R12 no second pulse
        do_reset();
        arm();
        run(8191);
        check(rst_drive_en, 1'b1, "R7", "drive on timeout");
        len = 0;
        while (rst_pulse && len < 300) begin
            len++;
            @(negedge clk);
        end
        check_int(len, 98, "R6", "pulse length");
        run(8300);
        check(rst_pulse, 1'b0, "R12", "no second pulse without key");

        // R7 disabled output
        do_reset();
        rst_out_dis = 1'b1;
        arm();
        run(8191);
        check(rst_pulse, 1'b1, "R7", "request with output disabled");
        check(rst_drive_en, 1'b0, "R7", "no drive when disabled");
        rst_out_dis = 1'b0;

        // R2 R11 cancelled key leaves it disabled
        do_reset();
        wr(8'h1E);
        wr(8'h55);
        wr(8'hE1);
        run(8191);
        check(rst_pulse, 1'b0, "R11", "cancelled key");
        // R11 repeated first byte still valid
        wr(8'h1E);
        wr(8'h1E);
        wr(8'hE1);
        run(8191);
        check(rst_pulse, 1'b1, "R11", "repeated first byte");

        // R2 lone second byte does not enable
        do_reset();
        wr(8'hE1);
        run(8191);
        check(rst_pulse, 1'b0, "R2", "lone E1h");

        // R3 R5 stray write keeps it on, key clears count
        do_reset();
        arm();
        run(5000);
        wr(8'h00);
        arm();
        run(8190);
        check(rst_pulse, 1'b0, "R5", "serviced count restarted");
        run(1);
        check(rst_pulse, 1'b1, "R3", "still enabled after stray write");

        // R10 wake hold
        do_reset();
        arm();
        run(3000);
        pdown = 1'b1;
        wake_n = 1'b0;
        run(200);
        pdown = 1'b0;
        run(4000);
        wake_n = 1'b1;
        @(negedge clk);
        run(5190);
        check(rst_pulse, 1'b0, "R10", "held until wake high");
        run(1);
        check(rst_pulse, 1'b1, "R10", "counts after wake high");

        // R1 reset discards a running count
        do_reset();
        arm();
        run(6000);
        do_reset();
        run(8191);
        check(rst_pulse, 1'b0, "R1", "reset disables");

        finish_up();
    end
endmodule